// File: doc/BRIEF.md
# Flash Write-Status Read Generator

This block models the read side of an asynchronous parallel NOR flash while an internal program or erase operation is running. A start pulse carries an operation kind, a target word address and, for a program, the data word. The block then stays busy for a fixed number of clock cycles, set by a parameter for each kind of operation. During that time every host read returns a polling status word instead of array contents. When the operation completes, the block updates its behavioural storage array, raises a one-cycle done flag and goes back to returning true array data.

The status word gives software two ways to find the end of a write. Bit 7 is a data-complement bit: for a program it is the inverse of bit 7 of the word being written, and for an erase it is 0. Bit 6 is a toggle bit that changes between consecutive reads. Any start request that arrives while an operation is running is discarded. This covers the abort and reset requests as well, so the operation in progress always finishes unchanged.

The storage array is `2**ADDR_W` words of 16 bits. A sector is `2**SECT_W` words and a block is `2**BLK_W` words.

Top module: `flash_status_reader`

## Requirements
- R1: After reset the block is idle, with busy and done both 0, and every word of the array reads 16'hFFFF.
- R2: A start accepted while idle raises busy in the next cycle. Busy stays high for exactly the duration set for the operation kind (PROG_CYC for a program). done is 1 for exactly one cycle, which is the first cycle after busy falls.
- R3: A program (startKind 2'd0) to a word stores the old contents AND the programmed data, so a program can only clear bits.
- R4: While a program is busy, every read returns a status word that does not depend on the address. Bit 7 is the inverse of bit 7 of the programmed data, bit 6 is the toggle bit, and bits 15:8 and 5:0 are 0.
- R5: While any erase is busy, bit 7 of a read is 0 and the status format is the same as in R4. After the erase completes, the erased words read 16'hFFFF.
- R6: While busy, the toggle bit inverts once at each falling edge of rdEn. It holds its value while rdEn stays high, so successive distinct reads see alternate values.
- R7: While idle, the toggle bit does not change. The first read of the next operation shows the value left by the last read of the previous operation.
- R8: A sector erase (startKind 2'd1) sets to 16'hFFFF every word whose address bits [ADDR_W-1:SECT_W] match those of startAddr. All other words are left unchanged. It lasts ERASE_CYC cycles.
- R9: A block erase (startKind 2'd2) sets to 16'hFFFF every word whose address bits [ADDR_W-1:BLK_W] match those of startAddr. All other words are left unchanged.
- R10: A chip erase (startKind 2'd3) sets every word to 16'hFFFF and lasts CHIP_CYC cycles.
- R11: A startValid that arrives while busy is ignored. It changes neither the running operation's kind, target or duration, nor any array word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | One-cycle request to begin an internal operation |
| startKind | input | 2 | Operation kind: 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| startAddr | input | ADDR_W | Target word address (any address inside the region for erases) |
| startData | input | 16 | Data word for a program |
| rdEn | input | 1 | Host read strobe, active high |
| rdAddr | input | ADDR_W | Host read address |
| rdData | output | 16 | Array word when idle, polling status word when busy |
| busy | output | 1 | Internal operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Busy rises at the clock edge that accepts the start, so the bench samples it on the falling edge that follows. It then counts falling-edge samples while busy is high and compares the count with the parameter for that kind. done and the updated array word are due at the same edge where busy falls, so the bench checks both on the first falling edge at which busy reads 0. rdData is combinational from the address and the state, so the bench samples it one nanosecond after it drives rdEn. The toggle bit is sampled only on a read that begins after the clock edge which saw the previous read's strobe fall, because that edge is where the flip lands.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_BLOCK = 2'd2,
    OP_CHIP  = 2'd3
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    busy;    // operation running, reads show status
    logic    commit;  // last busy cycle: apply the array update
    opKind_e kind;    // latched operation kind
    logic    tgl;     // current toggle-bit value
  } ctlStrobes_t;

  localparam int unsigned WORD_W = 16;

endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned PROG_CYC  = 5,
  parameter int unsigned ERASE_CYC = 12,
  parameter int unsigned CHIP_CYC  = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startValid,
  input  logic [1:0]          startKind,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [WORD_W-1:0]   startData,
  input  logic                rdEn,
  output ctlStrobes_t         strb,
  output logic [ADDR_W-1:0]   opAddr,
  output logic [WORD_W-1:0]   opData,
  output logic                done
);

  localparam int unsigned MAX_CYC = (CHIP_CYC > ERASE_CYC) ?
                                    ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC) :
                                    ((ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC);
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] CHIP_LOAD  = CNT_W'(CHIP_CYC - 1);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  opKind_e          kindQ;
  logic             tglQ;
  logic             prevRdQ;
  logic [CNT_W-1:0] loadVal;
  logic             lastCycle;
  opKind_e          reqKind;

  assign reqKind   = opKind_e'(startKind);
  assign lastCycle = busyQ && (cntQ == '0);

  always_comb begin
    case (reqKind)
      OP_PROG:  loadVal = PROG_LOAD;
      OP_CHIP:  loadVal = CHIP_LOAD;
      default:  loadVal = ERASE_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      cntQ    <= '0;
      kindQ   <= OP_PROG;
      opAddr  <= '0;
      opData  <= '0;
      tglQ    <= 1'b0;
      prevRdQ <= 1'b0;
      done    <= 1'b0;
    end else begin
      prevRdQ <= rdEn;
      done    <= lastCycle;
      if (busyQ && prevRdQ && !rdEn) begin
        tglQ <= ~tglQ;
      end
      if (!busyQ) begin
        if (startValid) begin
          busyQ  <= 1'b1;
          kindQ  <= reqKind;
          opAddr <= startAddr;
          opData <= startData;
          cntQ   <= loadVal;
        end
      end else if (cntQ == '0) begin
        busyQ <= 1'b0;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign strb.busy   = busyQ;
  assign strb.commit = lastCycle;
  assign strb.kind   = kindQ;
  assign strb.tgl    = tglQ;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> done); // R2
  AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |=> $stable(kindQ) && $stable(opAddr) && $stable(opData)); // R11
  AST_TGL_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |=> $stable(tglQ)); // R7

endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SECT_W = 2,
  parameter int unsigned BLK_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strb,
  input  logic [ADDR_W-1:0]   opAddr,
  input  logic [WORD_W-1:0]   opData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [WORD_W-1:0]   rdData
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  eraseHit;
  logic              pollBit;

  // Which words the latched erase covers
  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    always_comb begin
      case (strb.kind)
        OP_SECT:  eraseHit[i] = (IDX[ADDR_W-1:SECT_W] == opAddr[ADDR_W-1:SECT_W]);
        OP_BLOCK: eraseHit[i] = (IDX[ADDR_W-1:BLK_W]  == opAddr[ADDR_W-1:BLK_W]);
        OP_CHIP:  eraseHit[i] = 1'b1;
        default:  eraseHit[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.commit) begin
      if (strb.kind == OP_PROG) begin
        mem[opAddr] <= mem[opAddr] & opData;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (eraseHit[i]) mem[i] <= '1;
        end
      end
    end
  end

  assign pollBit = (strb.kind == OP_PROG) ? ~opData[7] : 1'b0;

  always_comb begin
    if (strb.busy) begin
      rdData = {8'h00, pollBit, strb.tgl, 6'h00};
    end else begin
      rdData = mem[rdAddr];
    end
  end

  AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && (strb.kind != OP_PROG) |=> mem[$past(opAddr)] == '1); // R5
  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && (strb.kind == OP_PROG) |=>
      (mem[$past(opAddr)] & ~$past(mem[opAddr])) == '0); // R3

endmodule

// File: rtl/flash_status_reader.sv
module flash_status_reader
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned SECT_W    = 2,
  parameter int unsigned BLK_W     = 4,
  parameter int unsigned PROG_CYC  = 5,
  parameter int unsigned ERASE_CYC = 12,
  parameter int unsigned CHIP_CYC  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [1:0]        startKind,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [15:0]       startData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [15:0]       rdData,
  output logic              busy,
  output logic              done
);

  ctlStrobes_t       strb;
  logic [ADDR_W-1:0] opAddr;
  logic [WORD_W-1:0] opData;

  fsr_ctrl #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startKind(startKind),
    .startAddr(startAddr), .startData(startData), .rdEn(rdEn),
    .strb(strb), .opAddr(opAddr), .opData(opData), .done(done)
  );

  fsr_datapath #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opAddr(opAddr), .opData(opData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  assign busy = strb.busy;

endmodule

// File: tb/flash_status_reader_tb.sv
module flash_status_reader_tb;

  localparam int PROG_CYC  = 5;
  localparam int ERASE_CYC = 12;
  localparam int CHIP_CYC  = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [1:0]  startKind = 2'd0;
  logic [5:0]  startAddr = '0;
  logic [15:0] startData = '0;
  logic        rdEn = 1'b0;
  logic [5:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        busy, done;

  int checks = 0;
  int failures = 0;
  logic tglModel = 1'b0;

  always #4 clk = ~clk;

  flash_status_reader u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startKind(startKind),
    .startAddr(startAddr), .startData(startData), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .busy(busy), .done(done)
  );

  // {addr, program data, expected word afterwards}
  localparam logic [37:0] VEC [8] = '{
    {6'd3,  16'h1234, 16'h1234},
    {6'd3,  16'hFF00, 16'h1200},
    {6'd10, 16'h00FF, 16'h00FF},
    {6'd10, 16'h0F0F, 16'h000F},
    {6'd17, 16'h8001, 16'h8001},
    {6'd40, 16'hA5A5, 16'hA5A5},
    {6'd63, 16'h0000, 16'h0000},
    {6'd4,  16'h7777, 16'h7777}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic doStart(input logic [1:0] k, input logic [5:0] a, input logic [15:0] d);
    startValid = 1'b1; startKind = k; startAddr = a; startData = d;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic readWord(input logic [5:0] a, output logic [15:0] v);
    rdEn = 1'b1; rdAddr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] statusWord(input logic b7, input logic t);
    return {8'h00, b7, t, 6'h00};
  endfunction

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " done at busy fall"}, {15'd0, done}, 16'd1);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] s1, s2, s3;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 done", {15'd0, done}, 16'd0);
    readWord(6'd5, v);  check("R1 word5", v, 16'hFFFF);
    readWord(6'd63, v); check("R1 word63", v, 16'hFFFF);

    // R2: program duration and done pulse
    doStart(2'd0, 6'd20, 16'hFFFF);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    check("R2 busy length", 16'(n), 16'(PROG_CYC));
    check("R2 done pulse", {15'd0, done}, 16'd1);
    @(negedge clk);
    check("R2 done single", {15'd0, done}, 16'd0);

    // R3/R4: vector table of programs
    for (int i = 0; i < 8; i++) begin
      doStart(2'd0, VEC[i][37:32], VEC[i][31:16]);
      readWord(6'd55, v);
      check("R4 program status", v, statusWord(~VEC[i][23], tglModel));
      tglModel = ~tglModel;
      waitIdle("R2");
      readWord(VEC[i][37:32], v);
      check("R3 programmed word", v, VEC[i][15:0]);
    end

    // R5/R8/R11: sector erase, with an ignored start while busy
    doStart(2'd1, 6'd2, 16'h0000);
    readWord(6'd3, v);
    check("R5 erase status", v, statusWord(1'b0, tglModel));
    tglModel = ~tglModel;
    n = 2;
    while (busy && n < 100) begin
      startValid = (n == 4); startKind = 2'd3; startAddr = 6'd10; startData = 16'h0000;
      n++;
      @(negedge clk);
    end
    startValid = 1'b0;
    check("R8 sector erase length", 16'(n), 16'(ERASE_CYC));
    check("R5 done after erase", {15'd0, done}, 16'd1);
    @(negedge clk);
    check("R11 no restart", {15'd0, busy}, 16'd0);
    readWord(6'd3, v);  check("R8 word3 erased", v, 16'hFFFF);
    readWord(6'd0, v);  check("R8 word0 erased", v, 16'hFFFF);
    readWord(6'd4, v);  check("R8 word4 kept", v, 16'h7777);
    readWord(6'd10, v); check("R11 word10 kept", v, 16'h000F);

    // R9: block erase of block 1
    doStart(2'd2, 6'd17, 16'h0000);
    readWord(6'd0, v);
    check("R5 block status", v, statusWord(1'b0, tglModel));
    tglModel = ~tglModel;
    waitIdle("R9");
    readWord(6'd17, v); check("R9 word17 erased", v, 16'hFFFF);
    readWord(6'd10, v); check("R9 word10 kept", v, 16'h000F);
    readWord(6'd40, v); check("R9 word40 kept", v, 16'hA5A5);

    // R7: idle reads do not move the toggle
    readWord(6'd40, v); check("R7 idle read", v, 16'hA5A5);
    readWord(6'd40, v); check("R7 idle read", v, 16'hA5A5);

    // R10/R6/R7: chip erase
    doStart(2'd3, 6'd0, 16'h0000);
    readWord(6'd1, v);
    check("R7 toggle continues", v, statusWord(1'b0, tglModel));
    tglModel = ~tglModel;
    rdEn = 1'b1; rdAddr = 6'd9;
    #1 s1 = rdData; @(negedge clk);
    #1 s2 = rdData; @(negedge clk);
    #1 s3 = rdData; @(negedge clk);
    rdEn = 1'b0; @(negedge clk);
    check("R6 held read 1", s1, statusWord(1'b0, tglModel));
    check("R6 held read 2", s2, statusWord(1'b0, tglModel));
    check("R6 held read 3", s3, statusWord(1'b0, tglModel));
    tglModel = ~tglModel;
    readWord(6'd2, v);
    check("R6 flipped after release", v, statusWord(1'b0, tglModel));
    tglModel = ~tglModel;
    n = 8;
    while (busy && n < 100) begin n++; @(negedge clk); end
    check("R10 chip erase length", 16'(n), 16'(CHIP_CYC));
    check("R10 done", {15'd0, done}, 16'd1);
    readWord(6'd10, v); check("R10 word10", v, 16'hFFFF);
    readWord(6'd40, v); check("R10 word40", v, 16'hFFFF);
    readWord(6'd63, v); check("R10 word63", v, 16'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule